// File: doc/BRIEF.md
# Sequential Full-Search Block Motion Estimator

This block finds the motion vector of one square block of the current frame by trying every displacement inside a search window and keeping the displacement with the lowest sum of absolute differences (SAD). The current block (BLK×BLK pixels) and the search window (WIN×WIN pixels, WIN = 2·RANGE + BLK) are held in two small on-chip pixel stores. Each store is filled through its own write port while the block is idle. A single absolute-difference-and-accumulate datapath then walks all candidates one pixel per cycle.

A one-cycle `start` launches a search. The controller moves through four named states. **IDLE** waits for `start`, and the IDLE→SCAN transition clears the running minimum and the best vector. **SCAN** adds one pixel difference per cycle. After the last pixel of a candidate, SCAN→EVAL. **EVAL** compares the candidate SAD with the running minimum and selects the next displacement. It goes EVAL→SCAN when more candidates remain and EVAL→FIN after the last one. **FIN** pulses `done` for one cycle, with the final vector and minimum SAD on the outputs, and then goes FIN→IDLE.

The search order is fixed: the row displacement is in the outer loop and the column displacement is in the inner loop. A candidate replaces the stored best only when its SAD is strictly smaller. On equal distortion, the earliest candidate in that order is kept.

Top module: `sad_motion_search`

## Requirements
- R1: While reset is held and right after it is released, `busy` and `done` are 0 and `best_dm`, `best_dn` and `best_sad` are 0.
- R2: Every candidate (m, n) with m and n in −RANGE..+RANGE is evaluated. That is (2·RANGE+1)² candidates, with m in the outer loop and n in the inner loop. The reported `best_dm` (row displacement) and `best_dn` (column displacement) are two's-complement values inside ±RANGE.
- R3: The SAD of candidate (m, n) is the sum over rows i and columns j (0..BLK−1) of |x(i,j) − y(i+m+RANGE, j+n+RANGE)|, where y(r,c) is window row r, column c. The current-block pixel x(i,j) is written at `cur_addr` = j·BLK + i, so the block is loaded column by column. The window pixel y(r,c) is written at `win_addr` = c·WIN + r.
- R4: At the start of each search the running minimum is set to the all-ones value of the SAD width and the best vector to (0,0).
- R5: The stored best is replaced only when a candidate's SAD is strictly less than the stored minimum. When all SADs are equal, the reported vector is (−RANGE, −RANGE).
- R6: After the clock edge that samples `start` in IDLE, `busy` is 1 for (2·RANGE+1)²·(BLK²+1)+1 cycles and `done` rises in the last of these cycles. `start` has no effect while `busy` is 1.
- R7: `done` is high for exactly one cycle. `best_dm`, `best_dn` and `best_sad` change only in a cycle where `done` is 1 and hold their values otherwise.
- R8: The SAD width is PIX_W + log2(BLK²) bits, so the largest possible SAD (BLK²·(2^PIX_W−1), which is 4080 for the defaults) is reported exactly.
- R9: Writes to either pixel store are ignored while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_we | input | 1 | Current-block store write enable |
| cur_addr | input | $clog2(BLK*BLK) | Current-block address, column-major |
| cur_data | input | PIX_W | Current-block pixel |
| win_we | input | 1 | Window store write enable |
| win_addr | input | $clog2(WIN*WIN) | Window address, column-major |
| win_data | input | PIX_W | Window pixel |
| start | input | 1 | Launch a search (sampled in IDLE only) |
| busy | output | 1 | Search in progress, including the FIN cycle |
| done | output | 1 | One-cycle completion pulse |
| best_dm | output | $clog2(RANGE+1)+1 | Signed best row displacement |
| best_dn | output | $clog2(RANGE+1)+1 | Signed best column displacement |
| best_sad | output | PIX_W+$clog2(BLK*BLK) | Minimum SAD found |

## Verification
The assertions check on every cycle that `done` lasts one cycle and only occurs while busy, that `busy` cannot drop before `done`, that the result outputs hold outside the done cycle, and that the vector and SAD stay inside their legal ranges. Other behaviour can only be shown by the bench scenarios. These are the correct minimum for an embedded match, the tie rule on uniform data, the full-scale SAD with no overflow, the exact latency, and that a mid-search `start` or write leaves the result unchanged. A behavioural model compares every output on every cycle.

// File: rtl/sme_pkg.sv
package sme_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_EVAL,
        ST_FIN
    } sme_state_e;

endpackage

// File: rtl/sme_store.sv
module sme_store #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/sme_absacc.sv
module sme_absacc #(
    parameter int PIX_W = 8,
    parameter int SW    = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [PIX_W-1:0] a,
    input  logic [PIX_W-1:0] b,
    output logic [SW-1:0]    acc
);

    logic [PIX_W-1:0] diff;

    always_comb begin
        diff = (a >= b) ? (a - b) : (b - a);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc <= '0;
        end else if (en) begin
            acc <= acc + SW'(diff);
        end
    end

endmodule

// File: rtl/sad_motion_search.sv
module sad_motion_search
    import sme_pkg::*;
#(
    parameter int BLK   = 4,
    parameter int RANGE = 2,
    parameter int PIX_W = 8,
    localparam int WIN  = 2 * RANGE + BLK,
    localparam int CA   = $clog2(BLK * BLK),
    localparam int WA   = $clog2(WIN * WIN),
    localparam int VW   = $clog2(RANGE + 1) + 1,
    localparam int SW   = PIX_W + $clog2(BLK * BLK)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cur_we,
    input  logic [CA-1:0]        cur_addr,
    input  logic [PIX_W-1:0]     cur_data,
    input  logic                 win_we,
    input  logic [WA-1:0]        win_addr,
    input  logic [PIX_W-1:0]     win_data,
    input  logic                 start,
    output logic                 busy,
    output logic                 done,
    output logic signed [VW-1:0] best_dm,
    output logic signed [VW-1:0] best_dn,
    output logic [SW-1:0]        best_sad
);

    localparam int IW   = $clog2(BLK);
    localparam int NC   = 2 * RANGE + 1;
    localparam int MW   = $clog2(NC);
    localparam int DW   = MW + 1;
    localparam logic [SW-1:0] SAD_INIT = '1;

    sme_state_e state, nxt;

    logic [IW-1:0]        pi, pj;
    logic [MW-1:0]        mo, no;
    logic [SW-1:0]        acc, run_min;
    logic signed [VW-1:0] run_dm, run_dn, cand_dm, cand_dn;
    logic signed [DW-1:0] ext_dm, ext_dn;
    logic [CA-1:0]        cur_raddr;
    logic [WA-1:0]        win_raddr;
    logic [PIX_W-1:0]     cur_pix, win_pix;
    logic                 last_px, last_cand, better;

    // ---------------- pixel stores ----------------
    sme_store #(.W(PIX_W), .DEPTH(BLK * BLK)) u_cur_store (
        .clk   (clk),
        .we    (cur_we && (state == ST_IDLE)),
        .waddr (cur_addr),
        .wdata (cur_data),
        .raddr (cur_raddr),
        .rdata (cur_pix)
    );

    sme_store #(.W(PIX_W), .DEPTH(WIN * WIN)) u_win_store (
        .clk   (clk),
        .we    (win_we && (state == ST_IDLE)),
        .waddr (win_addr),
        .wdata (win_data),
        .raddr (win_raddr),
        .rdata (win_pix)
    );

    // ---------------- datapath ----------------
    sme_absacc #(.PIX_W(PIX_W), .SW(SW)) u_absacc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   ((state == ST_EVAL) || (state == ST_IDLE)),
        .en    (state == ST_SCAN),
        .a     (cur_pix),
        .b     (win_pix),
        .acc   (acc)
    );

    always_comb begin
        cur_raddr = CA'(int'(pj) * BLK + int'(pi));
        win_raddr = WA'((int'(pj) + int'(no)) * WIN + int'(pi) + int'(mo));
        last_px   = (pi == IW'(BLK - 1)) && (pj == IW'(BLK - 1));
        last_cand = (mo == MW'(NC - 1)) && (no == MW'(NC - 1));
        better    = acc < run_min;
        ext_dm    = $signed({1'b0, mo}) - DW'(RANGE);
        ext_dn    = $signed({1'b0, no}) - DW'(RANGE);
        cand_dm   = VW'(ext_dm);
        cand_dn   = VW'(ext_dn);
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start)     nxt = ST_SCAN;
            ST_SCAN: if (last_px)   nxt = ST_EVAL;
            ST_EVAL: nxt = last_cand ? ST_FIN : ST_SCAN;
            ST_FIN:  nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // ---------------- scan counters and running best ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pi <= '0; pj <= '0; mo <= '0; no <= '0;
            run_min <= SAD_INIT; run_dm <= '0; run_dn <= '0;
            best_sad <= '0; best_dm <= '0; best_dn <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        pi <= '0; pj <= '0; mo <= '0; no <= '0;
                        run_min <= SAD_INIT; run_dm <= '0; run_dn <= '0;
                    end
                end
                ST_SCAN: begin
                    if (pj == IW'(BLK - 1)) begin
                        pj <= '0;
                        pi <= (pi == IW'(BLK - 1)) ? '0 : pi + 1'b1;
                    end else begin
                        pj <= pj + 1'b1;
                    end
                end
                ST_EVAL: begin
                    if (better) begin
                        run_min <= acc; run_dm <= cand_dm; run_dn <= cand_dn;
                    end
                    if (no == MW'(NC - 1)) begin
                        no <= '0;
                        mo <= (mo == MW'(NC - 1)) ? '0 : mo + 1'b1;
                    end else begin
                        no <= no + 1'b1;
                    end
                    if (last_cand) begin
                        best_sad <= better ? acc     : run_min;
                        best_dm  <= better ? cand_dm : run_dm;
                        best_dn  <= better ? cand_dn : run_dn;
                    end
                end
                ST_FIN: begin
                end
                default: begin
                end
            endcase
        end
    end

    // ---------------- state-decoded outputs ----------------
    always_comb begin
        busy = (state != ST_IDLE);
        done = (state == ST_FIN);
    end

endmodule

// File: rtl/sme_checker.sv
module sme_checker #(
    parameter int RANGE = 2,
    parameter int BLK   = 4,
    parameter int PIX_W = 8,
    parameter int VW    = 3,
    parameter int SW    = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 busy,
    input logic                 done,
    input logic signed [VW-1:0] best_dm,
    input logic signed [VW-1:0] best_dn,
    input logic [SW-1:0]        best_sad
);

    localparam int SAD_TOP = BLK * BLK * ((1 << PIX_W) - 1);

    // R7: done lasts a single cycle
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: done only appears inside a busy search
    a_r6_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R6: a running search cannot be cut short by start
    a_r6_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R7: results hold outside the done cycle
    a_r7_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(best_sad) && $stable(best_dm) && $stable(best_dn)));

    // R2: vector components stay in range
    a_r2_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(best_dm) >= -RANGE) && (int'(best_dm) <= RANGE) &&
        (int'(best_dn) >= -RANGE) && (int'(best_dn) <= RANGE));

    // R8: reported SAD never exceeds the full-scale value
    a_r8_sad_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(best_sad) <= SAD_TOP);

endmodule

bind sad_motion_search sme_checker #(
    .RANGE (RANGE),
    .BLK   (BLK),
    .PIX_W (PIX_W),
    .VW    (VW),
    .SW    (SW)
) u_sme_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .best_dm  (best_dm),
    .best_dn  (best_dn),
    .best_sad (best_sad)
);

// File: tb/sad_motion_search_bench.sv
module sad_motion_search_bench;

    localparam int BLK = 4;
    localparam int RNG = 2;
    localparam int PW  = 8;
    localparam int WIN = 2 * RNG + BLK;
    localparam int CA  = $clog2(BLK * BLK);
    localparam int WA  = $clog2(WIN * WIN);
    localparam int VW  = $clog2(RNG + 1) + 1;
    localparam int SW  = PW + $clog2(BLK * BLK);
    localparam int LAT = (2 * RNG + 1) * (2 * RNG + 1) * (BLK * BLK + 1);
    localparam int SADMAX = (1 << SW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cur_we = 1'b0, win_we = 1'b0, start = 1'b0;
    logic [CA-1:0] cur_addr = '0;
    logic [WA-1:0] win_addr = '0;
    logic [PW-1:0] cur_data = '0, win_data = '0;
    logic busy, done;
    logic signed [VW-1:0] best_dm, best_dn;
    logic [SW-1:0] best_sad;

    always #4 clk = ~clk;

    sad_motion_search #(.BLK(BLK), .RANGE(RNG), .PIX_W(PW)) u_sad_motion_search (
        .clk(clk), .rst_n(rst_n),
        .cur_we(cur_we), .cur_addr(cur_addr), .cur_data(cur_data),
        .win_we(win_we), .win_addr(win_addr), .win_data(win_data),
        .start(start), .busy(busy), .done(done),
        .best_dm(best_dm), .best_dn(best_dn), .best_sad(best_sad)
    );

    int checks = 0;
    int failures = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int xm [BLK][BLK];
    int ym [WIN][WIN];
    int exp_busy = 0, exp_done = 0, exp_dm = 0, exp_dn = 0, exp_sad = 0;
    int cnt = 0, pm = 0, pn = 0, ps = 0;
    bit model_on = 0;

    function automatic void search(output int rm, output int rn, output int rs);
        rs = SADMAX; rm = 0; rn = 0;
        for (int m = -RNG; m <= RNG; m++) begin
            for (int n = -RNG; n <= RNG; n++) begin
                int d = 0;
                for (int i = 0; i < BLK; i++) begin
                    for (int j = 0; j < BLK; j++) begin
                        int t = xm[i][j] - ym[i + m + RNG][j + n + RNG];
                        d += (t < 0) ? -t : t;
                    end
                end
                if (d < rs) begin rs = d; rm = m; rn = n; end
            end
        end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            exp_busy = 0; exp_done = 0; exp_dm = 0; exp_dn = 0; exp_sad = 0; cnt = 0;
        end else if (!exp_busy) begin
            if (cur_we) xm[int'(cur_addr) % BLK][int'(cur_addr) / BLK] = int'(cur_data);
            if (win_we) ym[int'(win_addr) % WIN][int'(win_addr) / WIN] = int'(win_data);
            if (start) begin search(pm, pn, ps); exp_busy = 1; cnt = 0; end
        end else begin
            cnt++;
            if (cnt == LAT) begin
                exp_done = 1; exp_dm = pm; exp_dn = pn; exp_sad = ps;
            end else if (cnt == LAT + 1) begin
                exp_busy = 0; exp_done = 0;
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (model_on) begin
            check(busy == exp_busy[0], "R6 busy", busy, exp_busy);
            check(done == exp_done[0], "R7 done", done, exp_done);
            check(int'(best_dm) == exp_dm, "R2 best_dm", best_dm, exp_dm);
            check(int'(best_dn) == exp_dn, "R2 best_dn", best_dn, exp_dn);
            check(int'(best_sad) == exp_sad, "R3 best_sad", best_sad, exp_sad);
        end
    end

    // ---------------- stimulus helpers ----------------
    int lfsr = 32'h1ACE5;
    function automatic int rnd();
        lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
        return lfsr & 255;
    endfunction

    task automatic wr_cur(input int i, input int j, input int v);
        @(negedge clk);
        cur_we = 1'b1; cur_addr = CA'(j * BLK + i); cur_data = PW'(v);
        @(negedge clk);
        cur_we = 1'b0;
    endtask

    task automatic wr_win(input int r, input int c, input int v);
        @(negedge clk);
        win_we = 1'b1; win_addr = WA'(c * WIN + r); win_data = PW'(v);
        @(negedge clk);
        win_we = 1'b0;
    endtask

    task automatic run(output int lat);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done) begin @(negedge clk); lat++; end
    endtask

    task automatic expect_res(input string tag, input int dm, input int dn, input int sad);
        check(int'(best_dm) == dm, {tag, " dm"}, best_dm, dm);
        check(int'(best_dn) == dn, {tag, " dn"}, best_dn, dn);
        check(int'(best_sad) == sad, {tag, " sad"}, best_sad, sad);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy == 1'b0 && done == 1'b0, "R1 flags in reset", {busy, done}, 0);
        check(best_dm == 0 && best_dn == 0 && best_sad == 0, "R1 outputs in reset", best_sad, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0 && best_sad == 0, "R1 after release", best_sad, 0);
        model_on = 1;

        // R3 / R2: block embedded at displacement (+1,-2), column-major loading
        for (int r = 0; r < WIN; r++)
            for (int c = 0; c < WIN; c++) wr_win(r, c, rnd());
        for (int j = 0; j < BLK; j++)
            for (int i = 0; i < BLK; i++) begin
                wr_cur(i, j, 10 + 20 * i + 50 * j);
                wr_win(i + 1 + RNG, j - 2 + RNG, 10 + 20 * i + 50 * j);
            end
        run(lat);
        check(lat == LAT + 1, "R6 latency", lat, LAT + 1);
        expect_res("R3 embedded match", 1, -2, 0);

        // R7: outputs hold after done
        repeat (10) @(negedge clk);
        expect_res("R7 hold after done", 1, -2, 0);

        // R5: uniform data, tie resolved to first visited
        for (int r = 0; r < WIN; r++)
            for (int c = 0; c < WIN; c++) wr_win(r, c, 0);
        for (int i = 0; i < BLK; i++)
            for (int j = 0; j < BLK; j++) wr_cur(i, j, 0);
        run(lat);
        expect_res("R5 tie first visited", -RNG, -RNG, 0);

        // R8 / R4: full-scale SAD beats the all-ones initial minimum
        for (int i = 0; i < BLK; i++)
            for (int j = 0; j < BLK; j++) wr_cur(i, j, 255);
        run(lat);
        expect_res("R8 full scale", -RNG, -RNG, BLK * BLK * 255);

        // R6 / R9: start and a window write during a search are ignored
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (100) @(negedge clk);
        start = 1'b1; win_we = 1'b1; win_addr = '0; win_data = 8'd255;
        @(negedge clk);
        start = 1'b0; win_we = 1'b0;
        lat = 102;
        while (!done) begin @(negedge clk); lat++; end
        check(lat == LAT + 1, "R6 start ignored while busy", lat, LAT + 1);
        expect_res("R9 write ignored during search", -RNG, -RNG, BLK * BLK * 255);
        run(lat);
        expect_res("R9 store unchanged afterwards", -RNG, -RNG, BLK * BLK * 255);

        // R3: random contents, checked against the model every cycle
        for (int k = 0; k < 3; k++) begin
            for (int r = 0; r < WIN; r++)
                for (int c = 0; c < WIN; c++) wr_win(r, c, rnd());
            for (int i = 0; i < BLK; i++)
                for (int j = 0; j < BLK; j++) wr_cur(i, j, rnd());
            run(lat);
            expect_res("R3 random", pm, pn, ps);
        end

        repeat (5) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule